// File: doc/BRIEF.md
# Floating-Point Error Interrupt Controller

This block turns the CPU's active-low floating-point error indication into an interrupt request and runs the handshake that tells the CPU to ignore the pending error. It first passes the error pin through a synchronizer. When the synchronized error goes from inactive to active, the block latches an internal level-13 request, and that request drives the CPU interrupt line.

Error-handling software acknowledges the error by writing to I/O port 0x00F0. The write clears the latched request. If the error is still present, the write also drives the active-low ignore-error output. That output stays low for as long as the synchronized error remains active, and it is never low while the synchronized error is inactive.

A single enable bit from a configuration register gates the whole function. While it is clear, neither output is ever driven active.

Top module: `fperr_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `irq13`=0, `intr`=0 and `ignne_n`=1.
- R2: With `en`=1, a high-to-low change of `ferr_n` sets `irq13` on the (SYNC_STAGES+1)-th rising edge after the change is first sampled. `intr` always equals `irq13`.
- R3: A cycle with `en`=1, `io_wr`=1 and `io_addr`=0x00F0 clears `irq13` at the next edge. If the synchronized error is active, it also drives `ignne_n` low at that edge.
- R4: Once low, `ignne_n` stays low while the synchronized error stays active. It returns high on the edge where the synchronized error becomes inactive, which is SYNC_STAGES edges after `ferr_n` rises.
- R5: A write to 0x00F0 while the synchronized error is inactive leaves `ignne_n` high.
- R6: An error that stays active does not raise `irq13` again after it has been cleared. A new request needs `ferr_n` to go high and then low again.
- R7: The port match compares all 16 address bits and needs `io_wr`=1. Writes to 0x00F1 or 0x10F0, and 0x00F0 presented with `io_wr`=0, change neither output.
- R8: While `en`=0, `irq13`=0 and `ignne_n`=1. Clearing `en` with outputs active returns both to inactive at the next edge. An error edge that occurs while disabled is not latched later.
- R9: If a new error edge and a 0x00F0 write fall in the same cycle, `irq13` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Function enable from the configuration register |
| ferr_n | input | 1 | CPU floating-point error, active low, asynchronous |
| io_wr | input | 1 | One-cycle I/O write qualifier |
| io_addr | input | 16 | I/O address of the write |
| irq13 | output | 1 | Internal level-13 interrupt request |
| intr | output | 1 | Contribution to the CPU interrupt line |
| ignne_n | output | 1 | Ignore-numeric-error to the CPU, active low |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default 2. A single latency value could be hard-wired by mistake, so the wider chain shows that the request and release timing follows the parameter. The clear port stays at 0x00F0. That lets the bench probe neighbours that differ in the lowest and in an upper address bit. With the longer chain, an error edge and a port write can be placed in the same cycle on purpose, which exercises the set-over-clear ordering.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

  // Next value of the interrupt request latch.
  // Order: disabled, then new error edge, then clearing write.
  function automatic logic next_irq(input logic en, input logic rise,
                                    input logic hit, input logic cur);
    if (!en)      return 1'b0;
    else if (rise) return 1'b1;
    else if (hit)  return 1'b0;
    else           return cur;
  endfunction

  // Next value of the ignore-error state.
  // Cleared when disabled or when the error is gone; set by a clearing write.
  function automatic logic next_ign(input logic en, input logic act,
                                    input logic hit, input logic cur);
    if (!en || !act) return 1'b0;
    else if (hit)    return 1'b1;
    else             return cur;
  endfunction

endpackage

// File: rtl/fperr_sync.sv
module fperr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic act
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b1;
    else     sh[0] <= din_n;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh[i] <= 1'b1;
      else     sh[i] <= sh[i-1];
    end
  end

  assign act = ~sh[STAGES-1];
endmodule

// File: rtl/fperr_req.sv
module fperr_req
  import fperr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ferr_act,
  input  logic clr_hit,
  output logic ferr_rise,
  output logic irq
);
  logic act_q;

  assign ferr_rise = ferr_act & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      act_q <= ferr_act;
      irq   <= next_irq(en, ferr_rise, clr_hit, irq);
    end
  end
endmodule

// File: rtl/fperr_ign.sv
module fperr_ign
  import fperr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ferr_act,
  input  logic clr_hit,
  output logic ign_q,
  output logic ignne_n
);
  always_ff @(posedge clk) begin
    if (rst) ign_q <= 1'b0;
    else     ign_q <= next_ign(en, ferr_act, clr_hit, ign_q);
  end

  // Qualify with the live synchronized error so release is immediate.
  assign ignne_n = ~(ign_q & ferr_act);
endmodule

// File: rtl/fperr_irq_ctrl.sv
module fperr_irq_ctrl #(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT  = ADDR_W'('h00F0),
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ferr_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              irq13,
  output logic              intr,
  output logic              ignne_n
);
  logic ferr_act;
  logic ferr_rise;
  logic clr_hit;
  logic ign_q;

  assign clr_hit = en & io_wr & (io_addr == CLR_PORT);

  fperr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din_n(ferr_n), .act(ferr_act)
  );

  fperr_req u_req (
    .clk(clk), .rst(rst), .en(en), .ferr_act(ferr_act),
    .clr_hit(clr_hit), .ferr_rise(ferr_rise), .irq(irq13)
  );

  fperr_ign u_ign (
    .clk(clk), .rst(rst), .en(en), .ferr_act(ferr_act),
    .clr_hit(clr_hit), .ign_q(ign_q), .ignne_n(ignne_n)
  );

  assign intr = irq13;
endmodule

// File: rtl/fperr_irq_chk.sv
module fperr_irq_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic ferr_act,
  input logic ferr_rise,
  input logic clr_hit,
  input logic irq13,
  input logic intr,
  input logic ignne_n
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq13 && ignne_n));

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (en && ferr_rise) |=> irq13);

  a_r2_intr_follows: assert property (@(posedge clk) disable iff (rst)
    intr == irq13);

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    (en && clr_hit && !ferr_rise) |=> !irq13);

  a_r4_ign_holds: assert property (@(posedge clk) disable iff (rst)
    (!ignne_n && en) |=> (!ignne_n || !ferr_act || !en));

  a_r5_ign_from_write: assert property (@(posedge clk) disable iff (rst)
    $fell(ignne_n) |-> $past(clr_hit));

  a_r6_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(irq13) |-> $past(ferr_rise));

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!irq13 && ignne_n));
endmodule

bind fperr_irq_ctrl fperr_irq_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ferr_act(ferr_act),
  .ferr_rise(ferr_rise), .clr_hit(clr_hit), .irq13(irq13),
  .intr(intr), .ignne_n(ignne_n)
);

// File: tb/fperr_irq_ctrl_test.sv
module fperr_irq_ctrl_test;
  localparam int NS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        ferr_n = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        irq13, intr, ignne_n;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [NS-1:0] m_pipe = '0;
  logic m_prev = 1'b0, m_irq = 1'b0, m_ign = 1'b0;

  always #10 clk = ~clk;

  fperr_irq_ctrl #(.SYNC_STAGES(NS)) uut (
    .clk(clk), .rst(rst), .en(en), .ferr_n(ferr_n), .io_wr(io_wr),
    .io_addr(io_addr), .irq13(irq13), .intr(intr), .ignne_n(ignne_n)
  );

  function automatic logic exp_irq(logic e, logic r, logic h, logic c);
    if (!e) return 1'b0;
    if (r)  return 1'b1;
    if (h)  return 1'b0;
    return c;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic a, r, h;
    @(posedge clk);
    if (rst) begin
      m_pipe = '0; m_prev = 1'b0; m_irq = 1'b0; m_ign = 1'b0;
    end else begin
      a = m_pipe[NS-1];
      r = a & ~m_prev;
      h = en & io_wr & (io_addr == 16'h00F0);
      m_irq = exp_irq(en, r, h, m_irq);
      m_ign = (!en || !a) ? 1'b0 : (h ? 1'b1 : m_ign);
      m_prev = a;
      m_pipe = {m_pipe[NS-2:0], ~ferr_n};
    end
    @(negedge clk);
    check(tag, "irq13", irq13, m_irq);
    check(tag, "intr", intr, m_irq);
    check(tag, "ignne_n", ignne_n, ~(m_ign & m_pipe[NS-1]));
  endtask

  task automatic wr(logic [15:0] a, string tag);
    io_wr = 1'b1; io_addr = a;
    step(tag);
    io_wr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1 reset");
    rst = 1'b0; en = 1'b1;
    // R2: error edge latency and intr follow
    ferr_n = 1'b0;
    for (int i = 0; i < NS + 3; i++) step("R2 set");
    // R3: clearing write, ignore-error asserts
    wr(16'h00F0, "R3 clear");
    for (int i = 0; i < 4; i++) step("R4/R6 hold");
    // R4: release after error goes away
    ferr_n = 1'b1;
    for (int i = 0; i < NS + 2; i++) step("R4 release");
    // R5: write with no error
    wr(16'h00F0, "R5 no ign");
    for (int i = 0; i < 2; i++) step("R5 no ign");
    // R6: new edge after inactive
    ferr_n = 1'b0;
    for (int i = 0; i < NS + 2; i++) step("R6 new edge");
    // R7: address qualification
    wr(16'h00F1, "R7 addr");
    wr(16'h10F0, "R7 addr");
    io_addr = 16'h00F0; step("R7 no wr");
    step("R7 no wr");
    // R8: disable with request active, then ignore held error
    wr(16'h00F0, "R8 setup");
    en = 1'b0;
    for (int i = 0; i < 3; i++) step("R8 off");
    en = 1'b1;
    for (int i = 0; i < 4; i++) step("R8 no late edge");
    // R9: simultaneous edge and clearing write
    ferr_n = 1'b1;
    for (int i = 0; i < NS + 2; i++) step("R9 prep");
    ferr_n = 1'b0;
    for (int i = 0; i < NS; i++) step("R9 prep");
    wr(16'h00F0, "R9 set wins");
    step("R9 set wins");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 16) != 0;
      if (($urandom % 8) == 0) ferr_n = ~ferr_n;
      io_wr = ($urandom % 4) == 0;
      io_addr = (($urandom % 2) == 0) ? 16'h00F0 : 16'($urandom);
      step("random R2/R3/R4/R6");
    end
    io_wr = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule